// File: doc/BRIEF.md
# PHY Interrupt Event Controller

This block watches the status signals of an Ethernet physical-layer transceiver and turns changes in them into sticky event flags and a single interrupt line. Four level inputs (link up, 100 Mb/s speed, full duplex and cable energy present) are compared with their value on the previous clock, and a transition in either direction raises a flag. Two more flags come from an auto-negotiation-complete pulse and from any statistics counter whose most significant bit rises, which means the counter has reached half of its range.

The flags collect in a status word that management software reads. The read strobe clears every flag in one step. Each flag has its own enable bit, and a separate global enable gates all of them. The active-low interrupt output asserts only when the global enable is set and at least one pending flag has its enable set. Flags latch whether or not they are enabled, so software can poll for events without taking interrupts. The management bus framing is not part of the block. It appears here only as write strobes for the enable registers and a read strobe for the status word.

Top module: `phy_irq_ctrl`

## Requirements
- R1: While reset is asserted, the status word is 0, all per-event enables and the global enable are 0, and `irq_n_o` is 1.
- R2: A change in either direction on a level input sets its status bit at the next rising clock edge: link at bit 0, speed at bit 1, duplex at bit 2, energy at bit 3.
- R3: The first clock edge after reset release only captures the level inputs and the counter MSBs as the reference. Levels that are already high at reset release raise no event.
- R4: A high `an_done_i` sampled at a clock edge sets status bit 4.
- R5: Status bit 5 is set when any bit of `cnt_msb_i` goes from 0 to 1. A bit that stays high, or falls, raises no event. While one counter MSB stays high, a rising MSB on another counter still raises the event.
- R6: A status bit sets even when its enable bit or the global enable is 0. In that case `irq_n_o` stays 1.
- R7: `irq_n_o` is 0 exactly when the global enable is 1 and at least one status bit has its enable bit set. Enable bit k (k = 0..5) in `en_wdata_i` enables status bit k, and bit 0 of `gie_wdata_i` is the global enable. A write takes effect at the clock edge where its strobe is sampled.
- R8: `stat_o` shows the current status word. A clock edge that samples `stat_rd_i` high clears every status bit at once.
- R9: An event that is sampled at the same edge as a clearing read stays set after that edge.
- R10: Without a read, a set status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Link state level |
| speed_100_i | input | 1 | Speed state level |
| full_dup_i | input | 1 | Duplex state level |
| energy_i | input | 1 | Energy-detect state level |
| an_done_i | input | 1 | Auto-negotiation complete pulse |
| cnt_msb_i | input | NUM_CNT | Most significant bit of each statistics counter |
| en_wr_i | input | 1 | Write strobe for the per-event enables |
| en_wdata_i | input | 6 | Per-event enable value |
| gie_wr_i | input | 1 | Write strobe for the global enable |
| gie_wdata_i | input | 1 | Global enable value |
| stat_rd_i | input | 1 | Status read strobe (clears all flags) |
| stat_o | output | 6 | Latched status word |
| irq_n_o | output | 1 | Active-low level interrupt |

## Verification
Every status result is due one clock edge after its stimulus: an input change, a pulse or a rising counter MSB is sampled at that edge and shows on `stat_o` right after it. A read clears at the edge where it is sampled. The interrupt output depends only on registered state, so it follows an enable write or a status change after that same single edge. The bench applies inputs 1 ns after a rising edge, advances exactly one edge, and samples 1 ns after that edge. The enable sweeps cover all 64 enable masks under both global settings.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int EV_LINK    = 0;
  localparam int EV_SPEED   = 1;
  localparam int EV_DUPLEX  = 2;
  localparam int EV_ENERGY  = 3;
  localparam int EV_ANDONE  = 4;
  localparam int EV_CNTHALF = 5;
  localparam int NUM_LVL    = 4;
  localparam int NUM_EV     = 6;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/pie_change_det.sv
// Either-edge change detector for level inputs; first edge after reset arms only.
module pie_change_det #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] chg_o
);
  logic armed_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl_i[i];
    end
    always_comb chg_o[i] = armed_q & (lvl_i[i] ^ prev_q[i]);
  end
endmodule

// File: rtl/pie_rise_any.sv
// Raises one event when any counter MSB goes low to high.
module pie_rise_any #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] msb_i,
  output logic         rise_o
);
  logic armed_q;
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      prev_q  <= '0;
    end else begin
      armed_q <= 1'b1;
      prev_q  <= msb_i;
    end
  end

  always_comb begin
    rise   = msb_i & ~prev_q;
    rise_o = armed_q & (|rise);
  end
endmodule

// File: rtl/pie_status_reg.sv
// Sticky status flags; a read clears all, same-cycle events survive.
module pie_status_reg #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = (clr_i ? '0 : stat_q) | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/pie_irq_gate.sv
// Per-event and global enables; active-low interrupt from registered state.
module pie_irq_gate #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_wdata_i,
  input  logic         gie_wr_i,
  input  logic         gie_wdata_i,
  input  logic [W-1:0] stat_i,
  output logic         irq_n_o
);
  logic [W-1:0] en_q, en_d;
  logic         gie_q, gie_d;

  always_comb begin
    en_d  = en_wr_i  ? en_wdata_i  : en_q;
    gie_d = gie_wr_i ? gie_wdata_i : gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      gie_q <= gie_d;
    end
  end

  assign irq_n_o = ~(gie_q & (|(stat_i & en_q)));
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int NUM_CNT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_up_i,
  input  logic               speed_100_i,
  input  logic               full_dup_i,
  input  logic               energy_i,
  input  logic               an_done_i,
  input  logic [NUM_CNT-1:0] cnt_msb_i,
  input  logic               en_wr_i,
  input  logic [NUM_EV-1:0]  en_wdata_i,
  input  logic               gie_wr_i,
  input  logic               gie_wdata_i,
  input  logic               stat_rd_i,
  output logic [NUM_EV-1:0]  stat_o,
  output logic               irq_n_o
);
  logic [NUM_LVL-1:0] lvl, lvl_chg;
  logic               cnt_half;
  ev_vec_t            ev;

  always_comb begin
    lvl            = '0;
    lvl[EV_LINK]   = link_up_i;
    lvl[EV_SPEED]  = speed_100_i;
    lvl[EV_DUPLEX] = full_dup_i;
    lvl[EV_ENERGY] = energy_i;
  end

  pie_change_det #(.W(NUM_LVL)) u_chg (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .chg_o(lvl_chg)
  );

  pie_rise_any #(.N(NUM_CNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .msb_i(cnt_msb_i), .rise_o(cnt_half)
  );

  always_comb begin
    ev                = '0;
    ev[NUM_LVL-1:0]   = lvl_chg;
    ev[EV_ANDONE]     = an_done_i;
    ev[EV_CNTHALF]    = cnt_half;
  end

  pie_status_reg #(.W(NUM_EV)) u_stat (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .clr_i(stat_rd_i), .stat_o(stat_o)
  );

  pie_irq_gate #(.W(NUM_EV)) u_gate (
    .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .gie_wr_i(gie_wr_i), .gie_wdata_i(gie_wdata_i), .stat_i(stat_o),
    .irq_n_o(irq_n_o)
  );
endmodule

// File: rtl/phy_irq_ctrl_chk.sv
module phy_irq_ctrl_chk #(
  parameter int NUM_CNT = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               link_up_i,
  input logic               speed_100_i,
  input logic               full_dup_i,
  input logic               energy_i,
  input logic               an_done_i,
  input logic [NUM_CNT-1:0] cnt_msb_i,
  input logic               en_wr_i,
  input logic [5:0]         en_wdata_i,
  input logic               gie_wr_i,
  input logic               gie_wdata_i,
  input logic               stat_rd_i,
  input logic [5:0]         stat_o,
  input logic               irq_n_o
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_IDLE: assert (irq_n_o === 1'b1 && stat_o === 6'd0); // R1
  end

  AST_AN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    an_done_i |=> stat_o[4]); // R4

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (stat_o != 6'd0)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !an_done_i) |=> !stat_o[4]); // R8

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o))); // R10

  AST_READ_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && an_done_i) |=> stat_o[4]); // R9
endmodule

bind phy_irq_ctrl phy_irq_ctrl_chk #(.NUM_CNT(NUM_CNT)) u_chk (.*);

// File: tb/tb_phy_irq_ctrl.sv
module tb_phy_irq_ctrl;
  localparam int NC = 2;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] lv = 4'hF;
  logic an = 1'b0;
  logic [NC-1:0] cnt = '1;
  logic en_wr = 1'b0, gie_wr = 1'b0, gie_wd = 1'b0, rd = 1'b0;
  logic [5:0] en_wd = '0;
  logic [5:0] stat;
  logic irq_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  phy_irq_ctrl #(.NUM_CNT(NC)) dut (
    .clk(clk), .rst_n(rst_n), .link_up_i(lv[0]), .speed_100_i(lv[1]),
    .full_dup_i(lv[2]), .energy_i(lv[3]), .an_done_i(an), .cnt_msb_i(cnt),
    .en_wr_i(en_wr), .en_wdata_i(en_wd), .gie_wr_i(gie_wr), .gie_wdata_i(gie_wd),
    .stat_rd_i(rd), .stat_o(stat), .irq_n_o(irq_n)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_read();
    rd = 1'b1; tick(); rd = 1'b0;
  endtask

  task automatic wr_en(input int m, input bit g);
    en_wr = 1'b1; en_wd = 6'(m); gie_wr = 1'b1; gie_wd = g;
    tick();
    en_wr = 1'b0; gie_wr = 1'b0;
  endtask

  task automatic fire(input int b);
    if (b < 4) lv[b] = ~lv[b];
    else if (b == 4) an = 1'b1;
    else cnt[0] = 1'b1;
    tick();
    an = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(stat == 0, "R1 status", int'(stat), 0);
    chk(irq_n == 1'b1, "R1 irq", int'(irq_n), 1);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk(stat == 0, "R3 high levels at release", int'(stat), 0);

    // R2 both edges of every level input, then R8 clear
    for (int i = 0; i < 4; i++) begin
      for (int e = 0; e < 2; e++) begin
        lv[i] = ~lv[i];
        tick();
        chk(stat == 6'(1 << i), "R2 level change", int'(stat), 1 << i);
        chk(irq_n == 1'b1, "R6 no irq when disabled", int'(irq_n), 1);
        do_read();
        chk(stat == 0, "R8 read clears", int'(stat), 0);
      end
    end

    // all events at once; sweep every enable mask and global setting
    cnt = '0; tick();
    chk(stat == 0, "R5 falling msb", int'(stat), 0);
    lv = ~lv; an = 1'b1; cnt = 2'b01; tick(); an = 1'b0;
    chk(stat == 6'h3F, "R6 all latched", int'(stat), 63);
    for (int g = 0; g < 2; g++) begin
      for (int m = 0; m < 64; m++) begin
        wr_en(m, g[0]);
        chk(irq_n == !(g == 1 && m != 0), "R7 mask sweep", int'(irq_n), int'(!(g == 1 && m != 0)));
        chk(stat == 6'h3F, "R10 sticky", int'(stat), 63);
      end
    end
    do_read();
    chk(stat == 0, "R8 clear all", int'(stat), 0);
    cnt = '0; tick();

    // single events against every mask with global enable on
    for (int b = 0; b < 6; b++) begin
      wr_en(0, 1'b1);
      fire(b);
      chk(stat == 6'(1 << b), (b == 4) ? "R4 an pulse" : (b == 5) ? "R5 msb rise" : "R2 single",
          int'(stat), 1 << b);
      for (int m = 0; m < 64; m++) begin
        wr_en(m, 1'b1);
        chk(irq_n == !m[b], "R7 single bit", int'(irq_n), int'(!m[b]));
      end
      do_read();
      chk(irq_n == 1'b1, "R7 released after read", int'(irq_n), 1);
    end

    // R5: held msb gives nothing, second counter rising does
    tick(); tick(); tick();
    chk(stat == 0, "R5 held msb", int'(stat), 0);
    cnt[1] = 1'b1; tick();
    chk(stat == 6'h20, "R5 second counter", int'(stat), 32);
    do_read();

    // R9: event in the same cycle as the clearing read
    fire(4);
    chk(stat == 6'h10, "R4 setup", int'(stat), 16);
    lv[0] = ~lv[0]; rd = 1'b1; tick(); rd = 1'b0;
    chk(stat == 6'h01, "R9 same-cycle event kept", int'(stat), 1);
    an = 1'b1; rd = 1'b1; tick(); an = 1'b0; rd = 1'b0;
    chk(stat == 6'h10, "R9 pulse with read", int'(stat), 16);
    do_read();
    chk(stat == 0, "R8 final clear", int'(stat), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule